// File: doc/BRIEF.md
# Full-Period Pseudo-Noise Sequence Generator

This block produces a pseudo-random bit stream from an N-bit shift register with linear feedback. A build-time choice picks between two equivalent feedback arrangements. In the tapped-XOR form, several register bits are combined into one new bit that enters at the low end. In the masked form, the register shifts left and, whenever the departing top bit is 1, it is XORed with a polynomial mask. The mask holds the lower N coefficients of a degree-N primitive polynomial, with bit i being the coefficient of x^i. The serial output is the register's top bit, and the whole register is also visible.

An optional full-cycle extension adds a detector for "all bits below the top are zero". Its output is XORed into the feedback, which splices the all-zero pattern into the cycle, so the period becomes 2^N rather than 2^N-1. Without the extension, an all-zero seed would lock the generator. Such a seed is therefore replaced by all ones.

Each cycle the controller resolves one of four commands, in priority order: CMD_RESET (when `rst` is high), CMD_LOAD (when `load` is high), CMD_STEP (when `en` is high) and CMD_HOLD (otherwise). The register moves to the reset value, the corrected seed, the next sequence state, or its own value. These commands are the only transitions of the state register.

Top module: `lfsr_pn_gen`

## Requirements
- R1: A cycle with `rst` high sets `state` on the next clock edge to RESET_SEED (all ones by default). This has priority over `load` and `en`.
- R2: A cycle with `load` high and `rst` low puts `seed` into `state` at the next edge, whatever `en` is. With the full-cycle extension off, a `seed` of all zeros loads all ones instead.
- R3: With `rst`, `load` and `en` all low, `state` and `serial_out` keep their values.
- R4: In the tapped-XOR form, a step shifts `state` left by one. The new bit 0 is the XOR over i of TAPS[i] AND state[N-1-i], further XORed with z when the extension is on. Here z is 1 exactly when state[N-2:0] is all zeros.
- R5: In the masked form, a step gives next = (state << 1) XOR (f ? TAPS : 0). Here f = state[N-1] XOR z, with z as in R4 and applied only with the extension on.
- R6: Without the extension, from reset the sequence has period exactly 2^N-1. No state repeats within a period, and the all-zero state never appears.
- R7: With the extension, the period is exactly 2^N and every N-bit pattern appears once per period.
- R8: With the extension, the state 1 followed by N-1 zeros steps to all zeros. All zeros steps to 1 in the tapped-XOR form and to TAPS in the masked form.
- R9: Without the extension, the serial stream over one period has its longest zero run of length N-1, occurring once, and its longest one run of length N.
- R10: In the tapped-XOR form with the extension, the longest zero run and the longest one run of the serial stream are both N.
- R11: `serial_out` always equals state[N-1].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance the sequence by one state |
| load | input | 1 | Load `seed` into the register |
| seed | input | WIDTH | Seed value for a load |
| serial_out | output | 1 | Generated bit (register top bit) |
| state | output | WIDTH | Full register contents |

## Verification
The assertions assume that TAPS has bit 0 set, as every primitive polynomial does. Only then is the step map invertible, so that a nonzero state never collapses to zero. The checks that follow an entry into or exit from all zeros also rely on the control inputs being known from the first reset onward. The stimulus uses only tabulated primitive polynomials for N from 3 to 8 and always starts each generator with reset. It drives seeds and commands only between clock edges, so every property sees settled, known inputs.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;

    typedef enum logic {
        FORM_EXT = 1'b0,
        FORM_INT = 1'b1
    } lfsr_form_e;

    typedef enum logic [1:0] {
        CMD_HOLD  = 2'd0,
        CMD_STEP  = 2'd1,
        CMD_LOAD  = 2'd2,
        CMD_RESET = 2'd3
    } lfsr_cmd_e;

    // Lower coefficients (bit i = coefficient of x^i) of a primitive
    // polynomial of the given degree.
    function automatic logic [31:0] default_taps(input int unsigned n);
        case (n)
            2:       return 32'h0003;
            3:       return 32'h0003;
            4:       return 32'h0003;
            5:       return 32'h0005;
            6:       return 32'h0003;
            7:       return 32'h0003;
            8:       return 32'h0071;
            9:       return 32'h0011;
            10:      return 32'h0009;
            11:      return 32'h0005;
            12:      return 32'h0053;
            13:      return 32'h001B;
            14:      return 32'h002B;
            15:      return 32'h0003;
            16:      return 32'h100B;
            default: return 32'h0003;
        endcase
    endfunction

endpackage

// File: rtl/lfsr_zero_flag.sv
module lfsr_zero_flag #(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] cur,
    output logic             low_clear
);
    // All bits except the outgoing top bit are zero.
    always_comb begin
        low_clear = ~|cur[WIDTH-2:0];
    end
endmodule

// File: rtl/lfsr_step_ext.sv
module lfsr_step_ext #(
    parameter int unsigned     WIDTH = 8,
    parameter logic [WIDTH-1:0] TAPS = '1
) (
    input  logic [WIDTH-1:0] cur,
    input  logic             corr,
    output logic [WIDTH-1:0] nxt
);
    logic fb;

    always_comb begin
        fb = corr;
        for (int i = 0; i < int'(WIDTH); i++) begin
            if (TAPS[i]) begin
                fb = fb ^ cur[WIDTH-1-i];
            end
        end
        nxt = {cur[WIDTH-2:0], fb};
    end
endmodule

// File: rtl/lfsr_step_int.sv
module lfsr_step_int #(
    parameter int unsigned     WIDTH = 8,
    parameter logic [WIDTH-1:0] TAPS = '1
) (
    input  logic [WIDTH-1:0] cur,
    input  logic             corr,
    output logic [WIDTH-1:0] nxt
);
    logic fold;

    always_comb begin
        fold = cur[WIDTH-1] ^ corr;
        nxt  = {cur[WIDTH-2:0], 1'b0} ^ (fold ? TAPS : '0);
    end
endmodule

// File: rtl/lfsr_pn_gen.sv
module lfsr_pn_gen
    import lfsr_pkg::*;
#(
    parameter int unsigned      WIDTH      = 8,
    parameter lfsr_form_e       FORM       = FORM_EXT,
    parameter bit               FULL_CYCLE = 1'b0,
    parameter logic [WIDTH-1:0] TAPS       = WIDTH'(default_taps(WIDTH)),
    parameter logic [WIDTH-1:0] RESET_SEED = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             load,
    input  logic [WIDTH-1:0] seed,
    output logic             serial_out,
    output logic [WIDTH-1:0] state
);
    localparam logic [WIDTH-1:0] ALL_ONES = '1;
    localparam logic [WIDTH-1:0] RST_VAL  =
        (FULL_CYCLE || (RESET_SEED != '0)) ? RESET_SEED : ALL_ONES;

    logic [WIDTH-1:0] state_q;
    logic [WIDTH-1:0] step_val;
    logic [WIDTH-1:0] seed_safe;
    logic             low_clear;
    logic             corr;
    lfsr_cmd_e        cmd;

    lfsr_zero_flag #(.WIDTH(WIDTH)) u_zero (
        .cur       (state_q),
        .low_clear (low_clear)
    );

    assign corr = FULL_CYCLE ? low_clear : 1'b0;

    generate
        if (FORM == FORM_EXT) begin : g_ext
            lfsr_step_ext #(.WIDTH(WIDTH), .TAPS(TAPS)) u_step (
                .cur  (state_q),
                .corr (corr),
                .nxt  (step_val)
            );
        end else begin : g_int
            lfsr_step_int #(.WIDTH(WIDTH), .TAPS(TAPS)) u_step (
                .cur  (state_q),
                .corr (corr),
                .nxt  (step_val)
            );
        end
    endgenerate

    // Seed correction: a zero seed would lock the plain generator.
    always_comb begin
        if (!FULL_CYCLE && (seed == '0)) begin
            seed_safe = ALL_ONES;
        end else begin
            seed_safe = seed;
        end
    end

    // Command decode in priority order.
    always_comb begin
        if (rst) begin
            cmd = CMD_RESET;
        end else if (load) begin
            cmd = CMD_LOAD;
        end else if (en) begin
            cmd = CMD_STEP;
        end else begin
            cmd = CMD_HOLD;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        unique case (cmd)
            CMD_RESET: state_q <= RST_VAL;
            CMD_LOAD:  state_q <= seed_safe;
            CMD_STEP:  state_q <= step_val;
            CMD_HOLD:  state_q <= state_q;
        endcase
    end

    // Outputs.
    always_comb begin
        state      = state_q;
        serial_out = state_q[WIDTH-1];
    end
endmodule

// File: rtl/lfsr_pn_gen_chk.sv
module lfsr_pn_gen_chk
    import lfsr_pkg::*;
#(
    parameter int unsigned      WIDTH      = 8,
    parameter lfsr_form_e       FORM       = FORM_EXT,
    parameter bit               FULL_CYCLE = 1'b0,
    parameter logic [WIDTH-1:0] TAPS       = '1,
    parameter logic [WIDTH-1:0] RESET_SEED = '1
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             load,
    input logic [WIDTH-1:0] seed,
    input logic             serial_out,
    input logic [WIDTH-1:0] state
);
    localparam logic [WIDTH-1:0] ONES     = '1;
    localparam logic [WIDTH-1:0] TOP_ONLY = {1'b1, {(WIDTH-1){1'b0}}};
    localparam logic [WIDTH-1:0] LOW_ONE  = {{(WIDTH-1){1'b0}}, 1'b1};
    localparam logic [WIDTH-1:0] RST_EXP  =
        (FULL_CYCLE || (RESET_SEED != '0)) ? RESET_SEED : ONES;

    logic armed = 1'b0;
    always_ff @(posedge clk) begin
        armed <= armed | rst;
    end

    a_r1_reset_value: assert property (@(posedge clk)
        rst |=> state == RST_EXP);

    a_r2_load_seed: assert property (@(posedge clk) disable iff (rst || !armed)
        load |=> state == ((!FULL_CYCLE && $past(seed) == '0) ? ONES : $past(seed)));

    a_r3_hold_state: assert property (@(posedge clk) disable iff (rst || !armed)
        (!load && !en) |=> $stable(state));

    a_r3_hold_serial: assert property (@(posedge clk) disable iff (rst || !armed)
        (!load && !en) |=> $stable(serial_out));

    generate
        if (FORM == FORM_EXT) begin : g_ext
            a_r4_shift_body: assert property (@(posedge clk) disable iff (rst || !armed)
                (en && !load) |=> state[WIDTH-1:1] == $past(state[WIDTH-2:0]));
        end else begin : g_int
            a_r5_plain_shift: assert property (@(posedge clk) disable iff (rst || !armed)
                (en && !load && !state[WIDTH-1] && (state[WIDTH-2:0] != '0))
                |=> state == {$past(state[WIDTH-2:0]), 1'b0});
        end

        if (!FULL_CYCLE) begin : g_plain
            a_r6_never_zero: assert property (@(posedge clk) disable iff (rst || !armed)
                state != '0);
        end else begin : g_full
            a_r8_enter_zero: assert property (@(posedge clk) disable iff (rst || !armed)
                (en && !load && state == TOP_ONLY) |=> state == '0);
            a_r8_leave_zero: assert property (@(posedge clk) disable iff (rst || !armed)
                (en && !load && state == '0)
                |=> state == ((FORM == FORM_EXT) ? LOW_ONE : TAPS));
        end
    endgenerate
endmodule

bind lfsr_pn_gen lfsr_pn_gen_chk #(
    .WIDTH      (WIDTH),
    .FORM       (FORM),
    .FULL_CYCLE (FULL_CYCLE),
    .TAPS       (TAPS),
    .RESET_SEED (RESET_SEED)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .load       (load),
    .seed       (seed),
    .serial_out (serial_out),
    .state      (state)
);

// File: tb/lfsr_pn_gen_lane.sv
module lfsr_pn_gen_lane
    import lfsr_pkg::*;
#(
    parameter int unsigned N    = 4,
    parameter lfsr_form_e  FORM = FORM_EXT,
    parameter bit          FULL = 1'b0
) (
    input  logic clk,
    output logic done,
    output int   checks,
    output int   errors
);
    localparam int unsigned    SIZE = 1 << N;
    localparam logic [N-1:0]   P    = N'(default_taps(N));

    logic         rst;
    logic         en;
    logic         load;
    logic [N-1:0] seed;
    logic         so;
    logic [N-1:0] st;

    lfsr_pn_gen #(.WIDTH(N), .FORM(FORM), .FULL_CYCLE(FULL)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .load       (load),
        .seed       (seed),
        .serial_out (so),
        .state      (st)
    );

    bit           seen [0:SIZE-1];
    logic [N-1:0] succ [0:SIZE-1];
    bit           seq  [0:SIZE-1];

    function automatic logic [N-1:0] model(input logic [N-1:0] s);
        logic z;
        logic f;
        z = FULL && (s[N-2:0] == '0);
        if (FORM == FORM_EXT) begin
            f = z;
            for (int i = 0; i < int'(N); i++) f = f ^ (P[i] & s[N-1-i]);
            return {s[N-2:0], f};
        end
        f = s[N-1] ^ z;
        return {s[N-2:0], 1'b0} ^ (f ? P : '0);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s N=%0d form=%0d full=%0d %s: got %0d expected %0d",
                     req, N, FORM, FULL, what, act, exp);
        end
    endtask

    initial begin
        logic [N-1:0] first;
        logic [N-1:0] prev;
        int period;
        int dups;
        int len;
        int step_bad;
        int start;
        int run;
        bit cur;
        int maxz;
        int maxo;
        int cnt_long_z;
        done = 0; checks = 0; errors = 0;
        rst = 1; en = 0; load = 0; seed = '0;
        period = 0; dups = 0; len = 0; step_bad = 0;
        for (int i = 0; i < int'(SIZE); i++) begin seen[i] = 0; succ[i] = '0; seq[i] = 0; end
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 0; en = 1;
        chk(st == '1, "R1", "reset state", int'(st), int'(SIZE - 1));
        first = st; prev = st; seen[st] = 1; seq[0] = so; len = 1;
        for (int k = 1; k <= int'(SIZE) + 1; k++) begin
            @(negedge clk);
            if (st != model(prev)) step_bad++;
            succ[prev] = st;
            if (st == first) begin period = k; break; end
            if (seen[st]) dups++;
            seen[st] = 1;
            if (len < int'(SIZE)) seq[len] = so;
            len++;
            prev = st;
        end
        en = 0;
        if (FORM == FORM_EXT) chk(step_bad == 0, "R4", "mismatched steps", step_bad, 0);
        else                  chk(step_bad == 0, "R5", "mismatched steps", step_bad, 0);
        if (FULL) begin
            chk(period == int'(SIZE), "R7", "period", period, int'(SIZE));
            chk(dups == 0, "R7", "early repeats", dups, 0);
            chk(seen[0], "R7", "zero visited", int'(seen[0]), 1);
            chk(succ[SIZE/2] == '0, "R8", "successor of top-only", int'(succ[SIZE/2]), 0);
            if (FORM == FORM_EXT)
                chk(succ[0] == 1, "R8", "successor of zero", int'(succ[0]), 1);
            else
                chk(succ[0] == P, "R8", "successor of zero", int'(succ[0]), int'(P));
        end else begin
            chk(period == int'(SIZE) - 1, "R6", "period", period, int'(SIZE) - 1);
            chk(dups == 0, "R6", "early repeats", dups, 0);
            chk(!seen[0], "R6", "zero visited", int'(seen[0]), 0);
        end
        if (period > 1 && (!FULL || FORM == FORM_EXT)) begin
            start = 0;
            for (int i = 0; i < period; i++) begin
                if (seq[i] != seq[(i + period - 1) % period]) begin start = i; break; end
            end
            maxz = 0; maxo = 0; cnt_long_z = 0;
            cur = seq[start]; run = 0;
            for (int j = 0; j <= period; j++) begin
                if (j < period && seq[(start + j) % period] == cur) begin
                    run++;
                end else begin
                    if (!cur) begin
                        if (run > maxz) maxz = run;
                        if (run == int'(N) - 1) cnt_long_z++;
                    end else if (run > maxo) maxo = run;
                    if (j < period) begin cur = seq[(start + j) % period]; run = 1; end
                end
            end
            if (!FULL) begin
                chk(maxz == int'(N) - 1, "R9", "longest zero run", maxz, int'(N) - 1);
                chk(cnt_long_z == 1, "R9", "zero runs of N-1", cnt_long_z, 1);
                chk(maxo == int'(N), "R9", "longest one run", maxo, int'(N));
            end else begin
                chk(maxz == int'(N), "R10", "longest zero run", maxz, int'(N));
                chk(maxo == int'(N), "R10", "longest one run", maxo, int'(N));
            end
        end
        done = 1;
    end
endmodule

// File: tb/lfsr_pn_gen_test.sv
module lfsr_pn_gen_test;
    import lfsr_pkg::*;

    localparam int LANES = 24;

    logic       clk = 1'b0;
    logic       rst;
    logic       en;
    logic       load;
    logic [7:0] seed;
    logic       serial_out;
    logic [7:0] state;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    bit drive_done = 0;

    always #5 clk = ~clk;

    lfsr_pn_gen #(.WIDTH(8), .FORM(FORM_EXT), .FULL_CYCLE(1'b0)) uut (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .load       (load),
        .seed       (seed),
        .serial_out (serial_out),
        .state      (state)
    );

    logic lane_done [LANES];
    int   lane_chk  [LANES];
    int   lane_err  [LANES];

    for (genvar n = 3; n <= 8; n++) begin : g_n
        for (genvar f = 0; f < 2; f++) begin : g_f
            for (genvar x = 0; x < 2; x++) begin : g_x
                lfsr_pn_gen_lane #(.N(n), .FORM(lfsr_form_e'(f)), .FULL(x[0])) u_lane (
                    .clk    (clk),
                    .done   (lane_done[(n-3)*4 + f*2 + x]),
                    .checks (lane_chk[(n-3)*4 + f*2 + x]),
                    .errors (lane_err[(n-3)*4 + f*2 + x])
                );
            end
        end
    end

    typedef struct {
        logic [7:0] st;
        string      tag;
    } item_t;

    item_t      sb_q[$];
    logic [7:0] mdl;

    function automatic logic [7:0] step8(input logic [7:0] s);
        logic [7:0] p;
        logic       f;
        p = 8'h71;
        f = 1'b0;
        for (int i = 0; i < 8; i++) f = f ^ (p[i] & s[7-i]);
        return {s[6:0], f};
    endfunction

    task automatic drive(input bit r, input bit e, input bit l,
                         input logic [7:0] sd, input string tag);
        @(negedge clk);
        rst = r; en = e; load = l; seed = sd;
        if (r)      mdl = 8'hFF;
        else if (l) mdl = (sd == 8'h00) ? 8'hFF : sd;
        else if (e) mdl = step8(mdl);
        sb_q.push_back('{mdl, tag});
    endtask

    // Monitor: compares each expected item after the edge it belongs to.
    initial begin
        item_t it;
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                checks++;
                if (state !== it.st) begin
                    errors++;
                    $display("FAIL %s: state %h expected %h", it.tag, state, it.st);
                end
                checks++;
                if (serial_out !== it.st[7]) begin
                    errors++;
                    $display("FAIL R11: serial_out %b expected %b", serial_out, it.st[7]);
                end
            end
        end
    end

    task automatic report();
        int c;
        int e;
        c = checks; e = errors;
        for (int i = 0; i < LANES; i++) begin c += lane_chk[i]; e += lane_err[i]; end
        $display("  CHECKS %0d ERRORS %0d", c, e);
    endtask

    initial begin
        rst = 1; en = 0; load = 0; seed = 8'h00; mdl = 8'hFF;
        drive(1, 0, 0, 8'h00, "R1 reset");
        drive(1, 0, 0, 8'h00, "R1 reset");
        drive(0, 0, 0, 8'h5A, "R3 hold ignores seed");
        for (int i = 0; i < 20; i++) drive(0, 1, 0, 8'h00, "R4 step");
        drive(0, 1, 1, 8'h35, "R2 load over enable");
        drive(0, 0, 1, 8'h00, "R2 zero seed replaced");
        for (int i = 0; i < 3; i++) drive(0, 0, 0, 8'hC3, "R3 hold");
        for (int i = 0; i < 10; i++) drive(0, 1, 0, 8'h00, "R4 step after load");
        drive(0, 1, 1, 8'h01, "R2 load low seed");
        for (int i = 0; i < 8; i++) drive(0, 1, 0, 8'h00, "R4 step from 01");
        drive(1, 1, 1, 8'h12, "R1 reset priority");
        @(negedge clk);
        en = 0; load = 0; rst = 0;
        repeat (3) @(posedge clk);
        drive_done = 1;
    end

    initial begin
        wait (drive_done);
        for (int i = 0; i < LANES; i++) wait (lane_done[i]);
        #20;
        if (!finished) begin
            finished = 1;
            report();
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog: run did not complete");
            report();
            $finish;
        end
    end
endmodule